// File: doc/BRIEF.md
# Bit-Masked GPIO Data Port

This block is an 8-bit general-purpose I/O port on a simple register bus with single-cycle read and write strobes. Each pin is an input or an output, chosen by a direction register. Output pins are driven from a stored data register. Input pins are sampled through a two-stage synchronizer.

The data register is reachable at every word address in the lower 1 KiB window. The byte-address bits [9:2] of an access act as a per-pin mask. Software can therefore set or clear any group of pins with one write, and read any group of pins with one read, with no read-modify-write sequence. The direction register sits at a single word address just above that window.

The bus reset is asynchronous and active low. Its release is synchronized to the clock inside the block.

Top module: `gpio_masked_port`

## Requirements
- R1: While reset is asserted and after its release, the data register and the direction register hold 0x00, so pin_oe is 0x00, pin_out is 0x00 and bus_rdata is 0x00. Assertion takes effect without a clock edge. Release takes effect at the second rising clock edge after rst_n goes high.
- R2: A write with bus_addr[10] = 0 updates data bit n only when bus_addr[n+2] is 1, taking the new value from bus_wdata[n]. Every other data bit keeps its value. For example, writing 0xEB at 0x098 (mask 0x26) changes only bits 5, 2 and 1, to 1, 0 and 1.
- R3: A read with bus_addr[10] = 0 returns 0 for each bit n whose mask bit bus_addr[n+2] is 0. For example, reading 0x0C4 (mask 0x31) while the port value is 0xBE returns 0x30.
- R4: Every word offset from 0x000 to 0x3FC reaches the same data register. Offset 0x000 has an all-zero mask, so a write there changes nothing. The low two address bits are ignored.
- R5: The direction register is at offset 0x400. It is read and written in full, with no masking.
- R6: pin_oe equals the direction register, and pin_out equals the data register.
- R7: For a masked-in bit of a data read, an output pin (direction 1) returns the stored data bit, and an input pin (direction 0) returns the synchronized pin_in bit.
- R8: A pin_in change that is present at rising edge k is returned by a read strobe sampled at edge k+2. Strobes sampled at edges k and k+1 still return the old value.
- R9: bus_rdata is registered. It updates at the rising edge that samples bus_rd and holds its value in every cycle without bus_rd.
- R10: Offsets 0x404 to 0x7FC are unmapped. Writes to them change nothing, and reads from them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 11 | Byte address; bits [9:2] are the pin mask |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output levels |
| pin_oe | output | 8 | Pin output enables, 1 = drive |

## Verification
The bench targets masked writes that must leave the unmasked bits alone. A design that ignored the mask, or used the wrong address bits, would corrupt the neighbouring pins. It reads through partial masks on mixed-direction ports, where a design that returned stored data for input pins, or failed to zero the masked-out bits, would show the wrong value. It times a pin change against back-to-back reads, so that a synchronizer with too few or too many stages is caught by the edge on which the new value first appears. It also writes to the all-zero mask and to unmapped offsets, and checks that read data holds between strobes, which catches a design that decodes too loosely or drives read data combinationally.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } gpio_sel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W      = 8,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_sync,
  output logic [W-1:0]      data_o,
  output logic [W-1:0]      dir_o
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(1 << W);

  logic [WORD_W-1:0] word_idx;
  logic [W-1:0]      mask;
  gpio_sel_e         sel;
  logic              unused_addr_lo;

  assign word_idx       = bus_addr[ADDR_W-1:2];
  assign mask           = bus_addr[W+1:2];
  assign unused_addr_lo = ^bus_addr[1:0];

  always_comb begin
    if (word_idx < DIR_WORD)       sel = SEL_DATA;
    else if (word_idx == DIR_WORD) sel = SEL_DIR;
    else                           sel = SEL_NONE;
  end

  logic [W-1:0] data_q, data_d;
  logic         data_en;
  logic [W-1:0] dir_q, dir_d;
  logic         dir_en;
  logic [W-1:0] rdata_q, rdata_d;
  logic         rdata_en;
  logic [W-1:0] port_view;

  // per-pin source for reads: stored bit for outputs, sampled pin for inputs
  assign port_view = (dir_q & data_q) | (~dir_q & pin_sync);

  always_comb begin
    data_en  = bus_wr && (sel == SEL_DATA);
    data_d   = (data_q & ~mask) | (bus_wdata & mask);
    dir_en   = bus_wr && (sel == SEL_DIR);
    dir_d    = bus_wdata;
    rdata_en = bus_rd;
    unique case (sel)
      SEL_DATA: rdata_d = port_view & mask;
      SEL_DIR:  rdata_d = dir_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign data_o    = data_q;
  assign dir_o     = dir_q;

  p_unmasked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr[ADDR_W-1]) |=>
      ((data_q & ~$past(mask)) == ($past(data_q) & ~$past(mask))));

  p_masked_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_addr[ADDR_W-1]) |=> ((bus_rdata & ~$past(mask)) == '0));

  p_dir_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[ADDR_W-1] && (bus_addr[ADDR_W-2:2] == '0)) |=>
      (dir_o == $past(bus_wdata)));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  p_unmapped_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[ADDR_W-1] && (bus_addr[ADDR_W-2:2] != '0)) |=>
      (bus_rdata == '0));

  p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[ADDR_W-1] && (bus_addr[ADDR_W-2:2] != '0)) |=>
      ($stable(data_o) && $stable(dir_o)));
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port #(
  parameter int W          = 8,
  parameter int ADDR_W     = 11,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe
);
  logic         rst_n_int;
  logic [W-1:0] pin_sync;
  logic [W-1:0] data_w;
  logic [W-1:0] dir_w;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  gpio_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .din   (pin_in),
    .dout  (pin_sync)
  );

  gpio_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_sync  (pin_sync),
    .data_o    (data_w),
    .dir_o     (dir_w)
  );

  assign pin_out = data_w;
  assign pin_oe  = dir_w;

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n_int |-> (pin_oe == '0 && pin_out == '0 && bus_rdata == '0));
endmodule

// File: tb/gpio_masked_port_tb.sv
module gpio_masked_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [7:0]  pin_in;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  gpio_masked_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // vector: {is_write, byte offset, write data or expected read data}
  localparam int NV = 17;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 11'h400, 8'hF0},  // R5 dir: upper nibble outputs
    {1'b1, 11'h3FC, 8'hFF},  // R4 full mask write
    {1'b0, 11'h3FC, 8'hFA},  // R7 outputs from data, inputs from pins 0x5A
    {1'b1, 11'h098, 8'h00},  // R2 clear bits 5,2,1 -> 0xD9
    {1'b0, 11'h3FC, 8'hDA},  // R7 mixed view
    {1'b1, 11'h400, 8'hFF},  // R5 all outputs
    {1'b0, 11'h3FC, 8'hD9},  // R2 unmasked bits intact
    {1'b0, 11'h0C4, 8'h11},  // R3 mask 0x31
    {1'b1, 11'h000, 8'hFF},  // R4 zero mask, no change
    {1'b0, 11'h3FC, 8'hD9},  // R4
    {1'b1, 11'h099, 8'hEB},  // R2 0xEB at 0x098 (low bits ignored) -> 0xFB
    {1'b0, 11'h3FC, 8'hFB},  // R2
    {1'b0, 11'h400, 8'hFF},  // R5 read back dir unmasked
    {1'b1, 11'h404, 8'h00},  // R10 unmapped write
    {1'b0, 11'h404, 8'h00},  // R10 unmapped read
    {1'b0, 11'h400, 8'hFF},  // R10 dir unchanged
    {1'b0, 11'h3FC, 8'hFB}   // R10 data unchanged
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [10:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [10:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; pin_in = 8'h5A;
    repeat (3) @(negedge clk);
    check("R1 pin_oe in reset", pin_oe, 8'h00);
    check("R1 pin_out in reset", pin_out, 8'h00);
    check("R1 rdata in reset", bus_rdata, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(11'h400, rd); check("R1 dir after reset", rd, 8'h00);
    bus_read(11'h3FC, rd); check("R7 input pins after reset", rd, 8'h5A);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) bus_write(VEC[i][18:8], VEC[i][7:0]);
      else begin
        bus_read(VEC[i][18:8], rd);
        check($sformatf("R2/R3/R4/R5/R7/R10 vector %0d", i), rd, VEC[i][7:0]);
      end
    end

    // R6 pins follow registers
    check("R6 pin_oe", pin_oe, 8'hFF);
    check("R6 pin_out", pin_out, 8'hFB);

    // R3 example: port value 0xBE, read at 0x0C4 -> 0x30
    bus_write(11'h3FC, 8'hBE);
    bus_read(11'h0C4, rd); check("R3 example 0x0C4", rd, 8'h30);

    // R9 hold between strobes, even across a write
    repeat (2) @(negedge clk);
    check("R9 hold idle", bus_rdata, 8'h30);
    bus_write(11'h3FC, 8'h00);
    check("R9 hold over write", bus_rdata, 8'h30);

    // R8 synchronizer latency on input pins
    bus_write(11'h400, 8'h00);
    pin_in = 8'h00;
    repeat (4) @(negedge clk);
    pin_in = 8'h3C;
    bus_read(11'h3FC, rd); check("R8 edge k old", rd, 8'h00);
    bus_read(11'h3FC, rd); check("R8 edge k+1 old", rd, 8'h00);
    bus_read(11'h3FC, rd); check("R8 edge k+2 new", rd, 8'h3C);

    // R1 asynchronous assertion mid-run
    bus_write(11'h400, 8'hFF);
    bus_write(11'h3FC, 8'hA5);
    #3 rst_n = 1'b0;
    #2;
    check("R1 async pin_oe", pin_oe, 8'h00);
    check("R1 async pin_out", pin_out, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(11'h400, rd); check("R1 dir after re-reset", rd, 8'h00);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule